// File: doc/BRIEF.md
# Serial Wire Link Resynchronization Controller

This block supervises the target end of a two-wire serial debug link. It samples the data line once per clock and keeps track of whether host and target are in step. Each request starts with a start bit. The block frames the eight-bit request header, checks its parity and its trailing stop and park bits, and follows the 33-bit payload that comes after a write. The block has no dedicated link-reset pin. It infers a reset from the line itself when it sees a long run of high samples.

Whenever synchronization is in doubt, the output enable for the target's line driver is withdrawn. This happens after power-up, after a line reset, after a malformed header and during lockout. The enable comes back only when the host completes a reconnection by reading the identification register. Two corrupted write payloads in a row put the block into lockout. In lockout only a line reset is recognised. For each accepted header the block gives a one-cycle strobe with the decoded fields, so that the register file behind it can act on the request.

Top module: `swlink_sync`

## Requirements
- R1: A 1 sampled while idle starts an eight-bit header, sampled in this order: start=1, port select (1 = access port, 0 = debug port), read/not-write (1 = read), address bit 0, address bit 1, parity, stop=0, park=1. The parity bit must make the count of ones over port select, read/not-write and both address bits, parity included, even. An accepted header raises `hdr_strobe` for exactly one cycle, in the cycle after the park bit is sampled, and presents the decoded fields in that same cycle.
- R2: A header with wrong parity, stop=1 or park=0 gives no strobe and deasserts `drive_en` in the cycle after the park bit.
- R3: A low sample that follows at least RST_LEN (default 50) consecutive high samples is a line reset. It pulses `reset_seen` for one cycle and drops `drive_en`. A run of RST_LEN-1 highs followed by a low is not a line reset.
- R4: After power-up, a line reset or a loss of synchronization, only a debug-port read of address 00 (the ID register) is accepted. Any other well-formed header is discarded, with no strobe, `drive_en` left low and no data phase.
- R5: An accepted ID read sets `drive_en`, and `drive_en` stays high while the link remains synchronized.
- R6: An accepted write header is followed directly by 32 payload bits and one parity bit. These are never taken as headers. The payload is good when the parity bit makes the count of ones over all 33 bits even.
- R7: Two bad payloads with no good payload between them assert `locked` and drop `drive_en`. A good payload clears the consecutive-bad count.
- R8: While `locked` is high, headers produce no strobe and `drive_en` stays low. Only a line reset clears `locked`.
- R9: Any number of low idle samples may separate requests, and a start bit may follow the previous request at once with no idle sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| line_in | input | 1 | Sampled serial data line |
| drive_en | output | 1 | Target line-driver enable; high only while synchronized |
| hdr_strobe | output | 1 | One-cycle pulse for each accepted header |
| hdr_sel | output | 1 | Port select of the last accepted header (1 = access port) |
| hdr_rnw | output | 1 | Read/not-write of the last accepted header |
| hdr_addr | output | 2 | Address bits of the last accepted header |
| reset_seen | output | 1 | One-cycle pulse when a line reset is recognised |
| locked | output | 1 | High while in lockout |

## Verification
The assertions assume that `line_in` is a clean, already synchronized 0 or 1. They also assume it stays stable across each rising edge, and that the block is left to run freely once power-on reset is released. The bench meets these assumptions by changing the line only on falling clock edges, and only to 0 or 1. Its random traffic comes from a fixed-seed generator that mixes well-formed and corrupted headers, payloads with good and bad parity, idle gaps, and high runs just below and above the reset length. Every cycle is compared with a bench model written from the requirements.

// File: rtl/swlink_pkg.sv
package swlink_pkg;

  typedef enum logic [1:0] {
    LS_IDLE = 2'd0,
    LS_HDR  = 2'd1,
    LS_DATA = 2'd2,
    LS_LOCK = 2'd3
  } link_st_e;

  typedef struct packed {
    logic       sel;
    logic       rnw;
    logic [1:0] addr;
  } hdr_fields_t;

  localparam int HDR_BITS = 8;

endpackage

// File: rtl/swlink_runlen.sv
module swlink_runlen #(
  parameter int RST_LEN = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic rst_det
);
  localparam int CW = $clog2(RST_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          full;

  assign full    = (cnt_q == CW'(RST_LEN));
  assign rst_det = !line_in && full;

  always_comb begin
    cnt_d = cnt_q;
    if (!line_in)  cnt_d = '0;
    else if (!full) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_run_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(RST_LEN));

  assert_low_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !line_in |=> cnt_q == '0);

endmodule

// File: rtl/swlink_hdrchk.sv
module swlink_hdrchk
  import swlink_pkg::*;
(
  input  logic [HDR_BITS-1:0] hvec,
  output logic                frame_ok,
  output logic                is_id_read,
  output hdr_fields_t         fields
);
  logic par_ok;

  assign par_ok      = (hvec[5] == ^hvec[4:1]);
  assign frame_ok    = hvec[0] && par_ok && !hvec[6] && hvec[7];
  assign fields.sel  = hvec[1];
  assign fields.rnw  = hvec[2];
  assign fields.addr = hvec[4:3];
  assign is_id_read  = !hvec[1] && hvec[2] && (hvec[4:3] == 2'b00);

endmodule

// File: rtl/swlink_datachk.sv
module swlink_datachk #(
  parameter int DATA_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic line_in,
  output logic last,
  output logic bad
);
  localparam int DW = $clog2(DATA_BITS + 1);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          acc_q, acc_d;

  assign last = (cnt_q == DW'(DATA_BITS));
  assign bad  = last && (line_in != acc_q);

  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    if (clr) begin
      cnt_d = '0;
      acc_d = 1'b0;
    end else if (en && !last) begin
      cnt_d = cnt_q + 1'b1;
      acc_d = acc_q ^ line_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= 1'b0;
    end else if (clr || en) begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DW'(DATA_BITS));

endmodule

// File: rtl/swlink_sync.sv
module swlink_sync
  import swlink_pkg::*;
#(
  parameter int RST_LEN   = 50,
  parameter int DATA_BITS = 32,
  parameter int LOCK_BADS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  output logic       drive_en,
  output logic       hdr_strobe,
  output logic       hdr_sel,
  output logic       hdr_rnw,
  output logic [1:0] hdr_addr,
  output logic       reset_seen,
  output logic       locked
);
  localparam int IW = $clog2(HDR_BITS);
  localparam int BW = $clog2(LOCK_BADS + 1);

  link_st_e           st_q, st_d;
  logic               linked_q, linked_d;
  logic [BW-1:0]      bad_q, bad_d;
  logic [IW-1:0]      hidx_q, hidx_d;
  logic [HDR_BITS-1:0] hsh_q, hvec;
  logic               hsh_en;
  hdr_fields_t        fld_q, fld_d, fld_now;
  logic               strobe_q, strobe_d;
  logic               rseen_q, rseen_d;
  logic               rst_det, frame_ok, is_id, dclr, den, dlast, dbad;

  assign hvec = {line_in, hsh_q[HDR_BITS-1:1]};

  swlink_runlen #(.RST_LEN(RST_LEN)) u_run (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .rst_det(rst_det)
  );

  swlink_hdrchk u_hdr (
    .hvec(hvec), .frame_ok(frame_ok), .is_id_read(is_id), .fields(fld_now)
  );

  swlink_datachk #(.DATA_BITS(DATA_BITS)) u_dat (
    .clk(clk), .rst_n(rst_n), .clr(dclr), .en(den), .line_in(line_in),
    .last(dlast), .bad(dbad)
  );

  always_comb begin
    st_d     = st_q;
    linked_d = linked_q;
    bad_d    = bad_q;
    hidx_d   = hidx_q;
    hsh_en   = 1'b0;
    fld_d    = fld_q;
    strobe_d = 1'b0;
    rseen_d  = 1'b0;
    dclr     = 1'b0;
    den      = 1'b0;
    if (rst_det) begin
      st_d     = LS_IDLE;
      linked_d = 1'b0;
      bad_d    = '0;
      rseen_d  = 1'b1;
    end else begin
      case (st_q)
        LS_IDLE: begin
          if (line_in) begin
            hsh_en = 1'b1;
            hidx_d = IW'(1);
            st_d   = LS_HDR;
          end
        end
        LS_HDR: begin
          hsh_en = 1'b1;
          if (hidx_q == IW'(HDR_BITS - 1)) begin
            st_d = LS_IDLE;
            if (!frame_ok) begin
              linked_d = 1'b0;
            end else if (linked_q || is_id) begin
              strobe_d = 1'b1;
              fld_d    = fld_now;
              linked_d = 1'b1;
              if (!fld_now.rnw) begin
                st_d = LS_DATA;
                dclr = 1'b1;
              end
            end
          end else begin
            hidx_d = hidx_q + 1'b1;
          end
        end
        LS_DATA: begin
          den = 1'b1;
          if (dlast) begin
            st_d = LS_IDLE;
            if (dbad) begin
              bad_d = bad_q + 1'b1;
              if (bad_q == BW'(LOCK_BADS - 1)) begin
                st_d     = LS_LOCK;
                linked_d = 1'b0;
              end
            end else begin
              bad_d = '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= LS_IDLE;
      linked_q <= 1'b0;
      bad_q    <= '0;
      hidx_q   <= '0;
      hsh_q    <= '0;
      fld_q    <= '0;
      strobe_q <= 1'b0;
      rseen_q  <= 1'b0;
    end else begin
      st_q     <= st_d;
      linked_q <= linked_d;
      bad_q    <= bad_d;
      hidx_q   <= hidx_d;
      strobe_q <= strobe_d;
      rseen_q  <= rseen_d;
      fld_q    <= fld_d;
      if (hsh_en) hsh_q <= hvec;
    end
  end

  assign drive_en   = linked_q;
  assign hdr_strobe = strobe_q;
  assign hdr_sel    = fld_q.sel;
  assign hdr_rnw    = fld_q.rnw;
  assign hdr_addr   = fld_q.addr;
  assign reset_seen = rseen_q;
  assign locked     = (st_q == LS_LOCK);

  assert_strobe_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_strobe |=> !hdr_strobe);

  assert_reset_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen |-> !drive_en && !locked);

  assert_unlinked_id_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_strobe && !$past(drive_en) |-> !hdr_sel && hdr_rnw && hdr_addr == 2'b00);

  assert_strobe_links_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_strobe |-> drive_en);

  assert_lock_noen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !drive_en && !hdr_strobe);

  assert_lock_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> reset_seen);

endmodule

// File: tb/swlink_sync_test.sv
module swlink_sync_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_in = 1'b0;
  logic       drive_en, hdr_strobe, hdr_sel, hdr_rnw, reset_seen, locked;
  logic [1:0] hdr_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  int       m_run = 0, m_st = 0, m_hidx = 0, m_dcnt = 0, m_bad = 0;
  bit [7:0] m_h;
  bit       m_acc = 0, m_linked = 0;
  bit       e_str = 0, e_rst = 0, e_sel = 0, e_rnw = 0;
  bit [1:0] e_addr = 0;

  always #4 clk = ~clk;

  swlink_sync uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .drive_en(drive_en),
    .hdr_strobe(hdr_strobe), .hdr_sel(hdr_sel), .hdr_rnw(hdr_rnw),
    .hdr_addr(hdr_addr), .reset_seen(reset_seen), .locked(locked)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit [7:0] mkhdr(input bit sel, input bit rnw, input bit [1:0] a);
    bit [7:0] h;
    h[0] = 1'b1; h[1] = sel; h[2] = rnw; h[3] = a[0]; h[4] = a[1];
    h[5] = sel ^ rnw ^ a[0] ^ a[1]; h[6] = 1'b0; h[7] = 1'b1;
    return h;
  endfunction

  task automatic model_step(input bit b);
    bit ok;
    e_str = 0;
    e_rst = 0;
    if (!b && m_run >= 50) begin
      m_st = 0; m_linked = 0; m_bad = 0; e_rst = 1;
    end else begin
      case (m_st)
        0: if (b) begin m_h = '0; m_h[0] = 1'b1; m_hidx = 1; m_st = 1; end
        1: begin
          m_h[m_hidx] = b;
          if (m_hidx == 7) begin
            m_st = 0;
            ok = m_h[0] && (m_h[5] == (m_h[1] ^ m_h[2] ^ m_h[3] ^ m_h[4])) && !m_h[6] && m_h[7];
            if (!ok) m_linked = 0;
            else if (m_linked || (!m_h[1] && m_h[2] && !m_h[3] && !m_h[4])) begin
              e_str = 1; e_sel = m_h[1]; e_rnw = m_h[2]; e_addr = {m_h[4], m_h[3]};
              m_linked = 1;
              if (!m_h[2]) begin m_st = 2; m_dcnt = 0; m_acc = 0; end
            end
          end else m_hidx++;
        end
        2: begin
          if (m_dcnt < 32) begin m_acc ^= b; m_dcnt++; end
          else begin
            m_st = 0;
            if (b != m_acc) begin
              m_bad++;
              if (m_bad >= 2) begin m_st = 3; m_linked = 0; end
            end else m_bad = 0;
          end
        end
        default: ;
      endcase
    end
    m_run = b ? m_run + 1 : 0;
  endtask

  task automatic compare_all();
    chk("R1 strobe", hdr_strobe, e_str);
    chk("R5 drive_en", drive_en, m_linked);
    chk("R7 locked", locked, m_st == 3);
    chk("R3 reset_seen", reset_seen, e_rst);
    if (e_str) begin
      chk("R1 sel", hdr_sel, e_sel);
      chk("R1 rnw", hdr_rnw, e_rnw);
      chk("R1 addr", hdr_addr, e_addr);
    end
  endtask

  task automatic drive(input bit b);
    @(negedge clk);
    line_in = b;
    model_step(b);
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic send_hdr(input bit [7:0] h);
    for (int i = 0; i < 8; i++) drive(h[i]);
  endtask

  task automatic send_data(input bit [31:0] d, input bit good);
    for (int i = 0; i < 32; i++) drive(d[i]);
    drive(good ? ^d : ~^d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0);
  endtask

  task automatic high_run(input int n);
    for (int i = 0; i < n; i++) drive(1'b1);
    drive(1'b0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int strobes;
    bit [7:0] h;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R4 reset drive_en", drive_en, 0);
    chk("R8 reset locked", locked, 0);
    chk("R1 reset strobe", hdr_strobe, 0);

    // R4: write header before reconnection is discarded
    idle(2);
    send_hdr(mkhdr(0, 0, 2'b01));
    chk("R4 unlinked write strobe", hdr_strobe, 0);
    chk("R4 unlinked write drive_en", drive_en, 0);

    // R3: exact reset length and one short of it
    idle(3);
    high_run(50);
    chk("R3 reset at 50", reset_seen, 1);
    idle(2);
    high_run(49);
    chk("R3 no reset at 49", reset_seen, 0);
    idle(2);
    high_run(60);

    // R5/R1: ID read reconnects
    send_hdr(mkhdr(0, 1, 2'b00));
    chk("R5 id read strobe", hdr_strobe, 1);
    chk("R5 id read drive_en", drive_en, 1);
    // R9: back-to-back header, no idle
    send_hdr(mkhdr(1, 0, 2'b10));
    chk("R9 back-to-back strobe", hdr_strobe, 1);
    chk("R1 ap sel", hdr_sel, 1);
    chk("R1 addr field", hdr_addr, 2);
    // R6: payload shaped like headers is not framed
    strobes = 0;
    for (int i = 0; i < 4; i++) for (int j = 0; j < 8; j++) begin
      drive(mkhdr(0, 1, 2'b00) >> j);
      strobes += hdr_strobe;
    end
    drive(1'b0);
    chk("R6 no strobe in payload", strobes, 0);
    idle(1);

    // R2: parity error loses sync
    h = mkhdr(1, 1, 2'b01); h[5] = ~h[5];
    send_hdr(h);
    chk("R2 parity strobe", hdr_strobe, 0);
    chk("R2 parity drive_en", drive_en, 0);
    send_hdr(mkhdr(0, 1, 2'b00));
    h = mkhdr(0, 1, 2'b11); h[6] = 1'b1;
    send_hdr(h);
    chk("R2 stop drive_en", drive_en, 0);
    send_hdr(mkhdr(0, 1, 2'b00));

    // R7: bad, good, bad -> not locked; bad again -> locked
    send_hdr(mkhdr(1, 0, 2'b00)); send_data(32'hDEAD_BEEF, 0);
    send_hdr(mkhdr(1, 0, 2'b00)); send_data(32'h1234_5678, 1);
    send_hdr(mkhdr(1, 0, 2'b00)); send_data(32'h0F0F_0F0F, 0);
    chk("R7 not locked after reset of count", locked, 0);
    send_hdr(mkhdr(1, 0, 2'b00)); send_data(32'h0000_0001, 0);
    chk("R7 locked", locked, 1);
    chk("R7 locked drive_en", drive_en, 0);
    // R8: ID read ignored in lockout
    idle(2);
    send_hdr(mkhdr(0, 1, 2'b00));
    chk("R8 lockout strobe", hdr_strobe, 0);
    chk("R8 lockout drive_en", drive_en, 0);
    high_run(52);
    chk("R8 release", locked, 0);

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int k;
      k = int'($urandom % 10);
      case (k)
        0: idle(int'($urandom % 4));
        1, 2: send_hdr(mkhdr(0, 1, 2'b00));
        3, 4: begin
          h = mkhdr(1'($urandom), 1'($urandom), 2'($urandom));
          send_hdr(h);
          if (!h[2] && drive_en) send_data($urandom, ($urandom % 3) != 0);
        end
        5: begin
          h = mkhdr(1'($urandom), 1'($urandom), 2'($urandom));
          h[1 + int'($urandom % 7)] ^= 1'b1;
          send_hdr(h);
        end
        6: send_data($urandom, 1'($urandom));
        7: high_run(48 + int'($urandom % 5));
        default: idle(1);
      endcase
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule